// File: doc/BRIEF.md
# Verification Run Monitor

This block is the companion circuit placed beside a device whose internal program memory is being checked against a reference memory. The device under check emits an address strobe for every byte it compares, and each strobe pulse steps a local address counter. The counter's value goes out as the reference-memory address, together with active-low chip-select and output-enable, so the reference memory presents the expected byte. The device reports its cumulated comparison result on a pass/fail pin. The monitor samples that pin on each falling edge of the address strobe and keeps a sticky fail flag.

The run finishes at whichever comes first: the counter wrapping from all ones to zero (its carry), or the first falling edge of the device's program strobe. The monitor then enters its done state, raises `run_done` and shows the final result on `final_pass`. From then on it ignores strobe activity until the device is put back into reset. All device-side inputs are asynchronous. Each passes through a two-stage synchroniser on the local clock, and strobe edges are found from the synchronised levels.

The state machine has three states. `VW_IDLE` holds while the device reset is asserted; the counter and fail flag are cleared there. `VW_RUN` is entered by the "release" transition when the synchronised device reset goes low; strobes are counted and sampled in this state. `VW_DONE` is entered by the "carry end" transition (counter wrap) or by the "strobe end" transition (program strobe falling). The "device reset" transition returns any state to `VW_IDLE`.

Top module: `verify_watch`

## Requirements
- R1: While the local reset `rst_n` is low and just after it is released, `mem_addr` is 0, `run_done` is 0, `final_pass` is 0, and both `mem_cs_n` and `mem_oe_n` are 1.
- R2: While `dev_rst` (active high) is asserted, the monitor stays idle: `mem_addr` reads 0, `run_done` and `final_pass` are 0, the memory enables are 1, and strobe pulses have no effect.
- R3: In the running state each rising edge of `addr_strobe` (active high) increments `mem_addr` by exactly one, and `mem_cs_n` and `mem_oe_n` are both driven low.
- R4: `verdict` is taken into account only at falling edges of `addr_strobe`; a low level on it that is gone again before the falling edge does not affect the result.
- R5: A `verdict` level of 0 (fail) sampled at any falling edge during the run sets a sticky fail flag; later samples of 1 (pass) do not clear it, and only a device reset or local reset does.
- R6: A rising edge of `addr_strobe` that takes `mem_addr` from all ones to zero ends the run: `run_done` becomes 1 and `mem_addr` reads 0.
- R7: The first falling edge of `prog_strobe_n` (active low, idle high) during the run ends the run even though the counter has not wrapped, leaving `mem_addr` at its current value.
- R8: Once `run_done` is 1, further `addr_strobe` and `verdict` activity leaves `mem_addr`, `run_done` and `final_pass` unchanged until the next device reset.
- R9: `final_pass` is 1 only when `run_done` is 1 and no fail was sampled; while the run is still going it is 0.
- R10: Releasing `dev_rst` moves the monitor from idle to running, which enables the reference memory with the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| dev_rst | input | 1 | Device reset, active high, asynchronous |
| addr_strobe | input | 1 | Device address strobe, active high, asynchronous |
| verdict | input | 1 | Device pass/fail pin: 1 = pass, 0 = fail |
| prog_strobe_n | input | 1 | Device program strobe, active low; its first fall marks the end |
| mem_addr | output | ADDR_W | Reference memory address (counter value) |
| mem_cs_n | output | 1 | Reference memory chip select, active low |
| mem_oe_n | output | 1 | Reference memory output enable, active low |
| run_done | output | 1 | Run has ended |
| final_pass | output | 1 | Final verdict, valid while `run_done` is 1 |

## Verification
The first run uses only passing samples plus a short fail glitch placed while the strobe is high and ends on the counter carry. It separates sampling at the falling edge from level sensing and checks the wrap to zero. The second run puts one failing sample early, then passing ones, and ends on the program strobe before the wrap. It tells a sticky flag apart from a last-sample flag and shows the early end leaving the address in place. The third run is clean and ends on the program strobe, which shows that the result depends only on the samples and not on the kind of end. Strobe pulses sent while the device is held in reset and after completion show that the address and result are frozen in both states.

// File: rtl/verify_watch_pkg.sv
package verify_watch_pkg;

    typedef enum logic [1:0] {
        VW_IDLE = 2'd0,
        VW_RUN  = 2'd1,
        VW_DONE = 2'd2
    } vw_state_e;

    // bit positions inside the synchronised input vector
    localparam int unsigned IN_STROBE = 0;
    localparam int unsigned IN_VERDICT = 1;
    localparam int unsigned IN_PROG = 2;
    localparam int unsigned IN_DEVRST = 3;
    localparam int unsigned IN_COUNT = 4;

    // values the inputs are assumed to hold while nothing happens
    localparam logic [IN_COUNT-1:0] IN_IDLE_LEVELS = 4'b1110;

endpackage

// File: rtl/vw_sync.sv
module vw_sync #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/vw_edge.sv
module vw_edge #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= level;
    end

    assign rise = level & ~prev;
    assign fall = ~level & prev;

endmodule

// File: rtl/vw_addr_ctr.sv
module vw_addr_ctr #(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              carry
);

    localparam logic [ADDR_W-1:0] TOP = '1;

    assign carry = step && (addr == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr <= '0;
        else if (clr)  addr <= '0;
        else if (step) addr <= addr + 1'b1;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (addr == ADDR_W'($past(addr) + 1'b1))) // R3
        else $error("counter did not step by one");

    AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !clr) |=> (addr == '0)) // R6
        else $error("carry without wrap to zero");

endmodule

// File: rtl/vw_verdict_latch.sv
module vw_verdict_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sample,
    input  logic level,
    output logic fail
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 fail <= 1'b0;
        else if (clr)               fail <= 1'b0;
        else if (sample && !level)  fail <= 1'b1;
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> fail) // R5
        else $error("fail flag dropped without clear");

    AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(sample && !level)) // R4
        else $error("fail flag set outside a sample point");

endmodule

// File: rtl/verify_watch.sv
module verify_watch
    import verify_watch_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_rst,
    input  logic              addr_strobe,
    input  logic              verdict,
    input  logic              prog_strobe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              run_done,
    output logic              final_pass
);

    vw_state_e state, state_nx;

    logic [IN_COUNT-1:0] raw_in, sync_in, rise_in, fall_in;
    logic dev_s, step, sample, carry, fail;
    logic prog_end;

    assign raw_in[IN_STROBE]  = addr_strobe;
    assign raw_in[IN_VERDICT] = verdict;
    assign raw_in[IN_PROG]    = prog_strobe_n;
    assign raw_in[IN_DEVRST]  = dev_rst;

    vw_sync #(
        .WIDTH  (IN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_IDLE_LEVELS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_in),
        .sync_out(sync_in)
    );

    vw_edge #(
        .WIDTH  (IN_COUNT),
        .RST_VAL(IN_IDLE_LEVELS)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(sync_in),
        .rise (rise_in),
        .fall (fall_in)
    );

    assign dev_s    = sync_in[IN_DEVRST];
    assign step     = (state == VW_RUN) && !dev_s && rise_in[IN_STROBE];
    assign sample   = (state == VW_RUN) && !dev_s && fall_in[IN_STROBE];
    assign prog_end = fall_in[IN_PROG];

    vw_addr_ctr #(
        .ADDR_W(ADDR_W)
    ) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (dev_s),
        .step (step),
        .addr (mem_addr),
        .carry(carry)
    );

    vw_verdict_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dev_s),
        .sample(sample),
        .level (sync_in[IN_VERDICT]),
        .fail  (fail)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= VW_IDLE;
        else        state <= state_nx;
    end

    // transitions: release, carry end, strobe end, device reset
    always_comb begin
        state_nx = state;
        if (dev_s) begin
            state_nx = VW_IDLE;
        end else begin
            unique case (state)
                VW_IDLE: state_nx = VW_RUN;
                VW_RUN:  if (carry || prog_end) state_nx = VW_DONE;
                VW_DONE: state_nx = VW_DONE;
                default: state_nx = VW_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_cs_n   = 1'b1;
        mem_oe_n   = 1'b1;
        run_done   = 1'b0;
        final_pass = 1'b0;
        unique case (state)
            VW_IDLE: ;
            VW_RUN: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            VW_DONE: begin
                run_done   = 1'b1;
                final_pass = !fail;
            end
            default: ;
        endcase
    end

    AST_DEVRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        dev_s |=> (mem_addr == '0 && !run_done && mem_cs_n)) // R2
        else $error("device reset did not clear the monitor");

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !dev_s) |=> run_done) // R8
        else $error("done dropped without device reset");

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !dev_s) |=> $stable(mem_addr)) // R8
        else $error("address moved after done");

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !dev_s) |=> $stable(final_pass)) // R9
        else $error("final result changed after done");

    AST_RUN_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VW_IDLE && !dev_s) |=> (!mem_cs_n && mem_addr == '0)) // R10
        else $error("release did not start the run at zero");

endmodule

// File: tb/verify_watch_test.sv
module verify_watch_test;

    localparam int unsigned AW = 4;

    typedef struct {
        string          tag;
        logic [AW-1:0]  addr;
        logic           en;
        logic           done;
        logic           pass;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_rst = 1'b1;
    logic addr_strobe = 1'b0;
    logic verdict = 1'b1;
    logic prog_strobe_n = 1'b1;
    logic [AW-1:0] mem_addr;
    logic mem_cs_n, mem_oe_n, run_done, final_pass;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    verify_watch #(.ADDR_W(AW), .SYNC_STAGES(2)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_rst      (dev_rst),
        .addr_strobe  (addr_strobe),
        .verdict      (verdict),
        .prog_strobe_n(prog_strobe_n),
        .mem_addr     (mem_addr),
        .mem_cs_n     (mem_cs_n),
        .mem_oe_n     (mem_oe_n),
        .run_done     (run_done),
        .final_pass   (final_pass)
    );

    // monitor: pops expected items and compares at the falling clock edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_tests++;
                if (mem_addr !== e.addr || mem_cs_n !== !e.en || mem_oe_n !== !e.en
                    || run_done !== e.done || final_pass !== e.pass) begin
                    n_fail++;
                    $display("FAIL %s: got addr=%0d cs_n=%b oe_n=%b done=%b pass=%b, expected addr=%0d cs_n=%b oe_n=%b done=%b pass=%b",
                             e.tag, mem_addr, mem_cs_n, mem_oe_n, run_done, final_pass,
                             e.addr, !e.en, !e.en, e.done, e.pass);
                end
            end
        end
    end

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_state(input string tag, input int addr, input bit en,
                                input bit done, input bit pass);
        exp_t e;
        e.tag = tag;
        e.addr = AW'(addr);
        e.en = en;
        e.done = done;
        e.pass = pass;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
        clocks(1);
    endtask

    // one strobe pulse; the verdict level is present at the falling edge
    task automatic pulse(input bit v, input bit glitch);
        addr_strobe = 1'b1;
        clocks(2);
        if (glitch) begin
            verdict = 1'b0;
            clocks(4);
            verdict = 1'b1;
            clocks(4);
        end
        verdict = v;
        clocks(3);
        addr_strobe = 1'b0;
        clocks(5);
        verdict = 1'b1;
        clocks(2);
    endtask

    task automatic device_reset();
        dev_rst = 1'b1;
        prog_strobe_n = 1'b1;
        clocks(8);
    endtask

    task automatic release_device();
        dev_rst = 1'b0;
        clocks(8);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clocks(3);
        expect_state("R1 in reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        clocks(2);
        expect_state("R1 after reset", 0, 0, 0, 0);

        // R2: strobes while device held in reset
        pulse(1'b0, 1'b0);
        pulse(1'b1, 1'b0);
        expect_state("R2 strobes ignored in device reset", 0, 0, 0, 0);

        // run 1: all pass, ends on carry
        release_device();
        expect_state("R10 release enables memory", 0, 1, 0, 0);
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        expect_state("R3 three strobes", 3, 1, 0, 0);
        pulse(1'b1, 1'b1);
        expect_state("R4 glitch while strobe high", 4, 1, 0, 0);
        for (int i = 4; i < 15; i++) pulse(1'b1, 1'b0);
        expect_state("R3 counter at top", 15, 1, 0, 0);
        pulse(1'b1, 1'b0);
        expect_state("R6 carry ends run", 0, 0, 1, 1);
        expect_state("R4 glitch left result passing", 0, 0, 1, 1);
        pulse(1'b0, 1'b0);
        pulse(1'b1, 1'b0);
        expect_state("R8 strobes after done ignored", 0, 0, 1, 1);

        // run 2: one early fail, ends on program strobe
        device_reset();
        expect_state("R2 device reset clears done", 0, 0, 0, 0);
        release_device();
        pulse(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0);
        expect_state("R9 no pass before done", 5, 1, 0, 0);
        prog_strobe_n = 1'b0;
        clocks(8);
        expect_state("R7 program strobe ends run", 5, 0, 1, 0);
        expect_state("R5 sticky fail after passing samples", 5, 0, 1, 0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        expect_state("R8 address frozen after done", 5, 0, 1, 0);

        // run 3: clean, ends on program strobe
        device_reset();
        release_device();
        for (int i = 0; i < 2; i++) pulse(1'b1, 1'b0);
        prog_strobe_n = 1'b0;
        clocks(8);
        expect_state("R9 clean run passes", 2, 0, 1, 1);
        device_reset();
        expect_state("R5 fail cleared by device reset", 0, 0, 0, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule